// File: doc/BRIEF.md
# Floating-Point Exception Status and Control Unit

This unit keeps the control word and the status word of a floating-point unit. Each cycle the arithmetic datapath may report the exceptions that one instruction raised. The unit ORs these reports into six sticky flags. It combines the flags with the mask bits of the control word to produce the error summary. It drives a pin-level error signal from that summary.

Software can write either word directly, for example when an environment is restored. The summary bit and its busy-bit copy are never taken from written data. They are always recomputed from the stored flags and the current masks. A restore that leaves an unmasked flag set therefore raises the error output in the first cycle after the load.

The datapath also updates the condition codes, the stack-top pointer and the stack-fault indication through this unit. Exception detection and the arithmetic itself are outside it.

Top module: `fpu_exc_ctrl`

## Requirements
- R1: `error_o` and status bit 7 (summary) are 1 exactly when some flag bit i (status bits 5:0) is 1 while control bit i (mask) is 0. They follow any change of flags or masks with no further register stage.
- R2: Status bit 15 always equals status bit 7.
- R3: A status load (`sw_ld_i`) takes the following fields from `sw_ld_data_i` on the next edge. The flags come from bits 5:0, the stack flag from bit 6 and C0, C1, C2 from bits 8, 9, 10. TOP comes from bits 13:11 and C3 from bit 14. Data bits 7 and 15 have no effect.
- R4: Reset and `init_i` set the control word to 16'h037F and the whole status word to 16'h0000.
- R5: When `rpt_valid_i` is 1, each set bit of `rpt_exc_i` is ORed into the flags. The bit order is invalid=0, denormal=1, zero-divide=2, overflow=3, underflow=4, precision=5. Flags never clear on their own, and reports with `rpt_valid_i` at 0 are ignored.
- R6: `clr_exc_i` clears the flags and the stack flag. A report in the same cycle is ORed in after the clear. TOP and the condition codes are not affected.
- R7: A valid report with `rpt_stk_i` set does three things: it sets flag bit 0, it sets the stack flag (bit 6), and it writes `rpt_c1_i` into C1 (bit 9). This C1 value wins over a same-cycle condition-code write.
- R8: A control load (`cw_ld_i`) stores all 16 bits of `cw_ld_data_i`. Bits 5:0 act as masks from the next cycle on.
- R9: Control bit 12 is stored but has no effect on the summary or on `error_o`.
- R10: `cc_wr_i` writes `cc_i[0]`, `[1]`, `[2]` and `[3]` to status bits 8, 9, 10 and 14. `top_wr_i` writes `top_i` to bits 13:11.
- R11: `init_i` has priority over a same-cycle load. A status load has priority over same-cycle reports, clears and updates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| init_i | input | 1 | Initialise both words |
| clr_exc_i | input | 1 | Clear the flags and the stack flag |
| rpt_valid_i | input | 1 | Exception report valid |
| rpt_exc_i | input | 6 | Reported exceptions |
| rpt_stk_i | input | 1 | Report is a stack fault |
| rpt_c1_i | input | 1 | Stack fault direction written to C1 |
| cc_wr_i | input | 1 | Condition-code write strobe |
| cc_i | input | 4 | C3..C0 |
| top_wr_i | input | 1 | TOP write strobe |
| top_i | input | 3 | New TOP |
| cw_ld_i | input | 1 | Control word load |
| cw_ld_data_i | input | 16 | Control word data |
| sw_ld_i | input | 1 | Status word load |
| sw_ld_data_i | input | 16 | Status word data |
| cw_o | output | 16 | Control word |
| sw_o | output | 16 | Status word |
| error_o | output | 1 | Unmasked exception pending |

## Verification
The bench builds the unit with its default parameters: six exception flags, a three-bit TOP and the 16'h037F reset word. With only six flags and six masks, every one of the 4096 flag/mask pairs is loaded and its summary checked against arithmetic computed in the bench. The sweep writes the opposite of the correct value into data bits 7 and 15, so any path from loaded data to the summary is caught. All 128 combinations of condition codes and TOP are also written and read back.

// File: rtl/fpu_exc_pkg.sv
package fpu_exc_pkg;
  localparam int NEXC   = 6;
  localparam int TOP_W  = 3;
  localparam int WORD_W = 16;

  localparam int EXC_INV  = 0;
  localparam int SW_SF    = 6;
  localparam int SW_ES    = 7;
  localparam int SW_C0    = 8;
  localparam int SW_C1    = 9;
  localparam int SW_C2    = 10;
  localparam int SW_TOPLO = 11;
  localparam int SW_C3    = 14;
  localparam int SW_BUSY  = 15;

  typedef logic [NEXC-1:0] exc_vec_t;

  typedef struct packed {
    logic [3:0]       cc;     // C3..C0
    logic [TOP_W-1:0] top;
    logic             sf;
    exc_vec_t         flags;
  } sw_state_t;
endpackage

// File: rtl/fpu_es_calc.sv
module fpu_es_calc
  import fpu_exc_pkg::*;
(
  input  exc_vec_t flags_i,
  input  exc_vec_t masks_i,
  output logic     es_o
);
  exc_vec_t unmasked;

  for (genvar i = 0; i < NEXC; i++) begin : g_unm
    assign unmasked[i] = flags_i[i] & ~masks_i[i];
  end

  assign es_o = |unmasked;
endmodule

// File: rtl/fpu_cw_reg.sv
module fpu_cw_reg
  import fpu_exc_pkg::*;
#(
  parameter logic [WORD_W-1:0] CW_RST = 16'h037F
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              init_i,
  input  logic              ld_i,
  input  logic [WORD_W-1:0] ld_data_i,
  output logic [WORD_W-1:0] cw_o
);
  logic [WORD_W-1:0] cw_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cw_q <= CW_RST;
    else if (init_i) cw_q <= CW_RST;
    else if (ld_i)   cw_q <= ld_data_i;
  end

  assign cw_o = cw_q;

  a_r4_cw_init: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_i |=> cw_o == CW_RST);
  a_r8_cw_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_i && !init_i) |=> cw_o == $past(ld_data_i));
endmodule

// File: rtl/fpu_sw_state.sv
module fpu_sw_state
  import fpu_exc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              init_i,
  input  logic              clr_i,
  input  logic              rpt_valid_i,
  input  exc_vec_t          rpt_exc_i,
  input  logic              rpt_stk_i,
  input  logic              rpt_c1_i,
  input  logic              cc_wr_i,
  input  logic [3:0]        cc_i,
  input  logic              top_wr_i,
  input  logic [TOP_W-1:0]  top_i,
  input  logic              ld_i,
  input  logic [WORD_W-1:0] ld_data_i,
  output sw_state_t         st_o
);
  sw_state_t st_q, st_d;
  logic      stk_fault;
  logic      unused_ld_bits;

  assign stk_fault      = rpt_valid_i & rpt_stk_i;
  assign unused_ld_bits = ^{ld_data_i[SW_ES], ld_data_i[SW_BUSY]};

  always_comb begin
    st_d = st_q;
    if (clr_i) begin
      st_d.flags = '0;
      st_d.sf    = 1'b0;
    end
    if (rpt_valid_i) st_d.flags = st_d.flags | rpt_exc_i;
    if (stk_fault) begin
      st_d.flags[EXC_INV] = 1'b1;
      st_d.sf             = 1'b1;
    end
    if (cc_wr_i)   st_d.cc    = cc_i;
    if (stk_fault) st_d.cc[1] = rpt_c1_i;
    if (top_wr_i)  st_d.top   = top_i;
    if (ld_i) begin
      // summary and busy bits are not taken from the data
      st_d.flags = ld_data_i[NEXC-1:0];
      st_d.sf    = ld_data_i[SW_SF];
      st_d.cc    = {ld_data_i[SW_C3], ld_data_i[SW_C2], ld_data_i[SW_C1], ld_data_i[SW_C0]};
      st_d.top   = ld_data_i[SW_TOPLO +: TOP_W];
    end
    if (init_i) st_d = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= '0;
    else         st_q <= st_d;
  end

  assign st_o = st_q;

  a_r5_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!init_i && !clr_i && !ld_i) |=> ((st_o.flags & $past(st_o.flags)) == $past(st_o.flags)));
  a_r7_stack_fault: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rpt_valid_i && rpt_stk_i && !init_i && !ld_i) |=>
      (st_o.flags[EXC_INV] && st_o.sf && st_o.cc[1] == $past(rpt_c1_i)));
  a_r3_load_fields: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_i && !init_i) |=> (st_o.flags == $past(ld_data_i[NEXC-1:0]) &&
                           st_o.top == $past(ld_data_i[SW_TOPLO +: TOP_W])));
  a_r4_init_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_i |=> st_o == '0);
  a_r6_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !rpt_valid_i && !init_i && !ld_i) |=> (st_o.flags == '0 && !st_o.sf));
endmodule

// File: rtl/fpu_exc_ctrl.sv
module fpu_exc_ctrl
  import fpu_exc_pkg::*;
#(
  parameter logic [15:0] CW_RST = 16'h037F
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        init_i,
  input  logic        clr_exc_i,
  input  logic        rpt_valid_i,
  input  logic [5:0]  rpt_exc_i,
  input  logic        rpt_stk_i,
  input  logic        rpt_c1_i,
  input  logic        cc_wr_i,
  input  logic [3:0]  cc_i,
  input  logic        top_wr_i,
  input  logic [2:0]  top_i,
  input  logic        cw_ld_i,
  input  logic [15:0] cw_ld_data_i,
  input  logic        sw_ld_i,
  input  logic [15:0] sw_ld_data_i,
  output logic [15:0] cw_o,
  output logic [15:0] sw_o,
  output logic        error_o
);
  sw_state_t st;
  logic      es;

  fpu_cw_reg #(.CW_RST(CW_RST)) u_cw (
    .clk_i, .rst_ni, .init_i,
    .ld_i(cw_ld_i), .ld_data_i(cw_ld_data_i), .cw_o(cw_o)
  );

  fpu_sw_state u_sw (
    .clk_i, .rst_ni, .init_i,
    .clr_i(clr_exc_i), .rpt_valid_i, .rpt_exc_i, .rpt_stk_i, .rpt_c1_i,
    .cc_wr_i, .cc_i, .top_wr_i, .top_i,
    .ld_i(sw_ld_i), .ld_data_i(sw_ld_data_i), .st_o(st)
  );

  fpu_es_calc u_es (
    .flags_i(st.flags), .masks_i(cw_o[NEXC-1:0]), .es_o(es)
  );

  assign sw_o = {es, st.cc[3], st.top, st.cc[2], st.cc[1], st.cc[0], es, st.sf, st.flags};
  assign error_o = es;

  a_r1_error_needs_unmasked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    error_o |-> ((sw_o[5:0] & ~cw_o[5:0]) != 6'd0));
  a_r1_unmasked_gives_error: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((sw_o[5:0] & ~cw_o[5:0]) != 6'd0) |-> error_o);
endmodule

// File: tb/tb_fpu_exc_ctrl.sv
module tb_fpu_exc_ctrl;
  logic        clk_i = 0, rst_ni = 0;
  logic        init_i = 0, clr_exc_i = 0, rpt_valid_i = 0, rpt_stk_i = 0, rpt_c1_i = 0;
  logic [5:0]  rpt_exc_i = 0;
  logic        cc_wr_i = 0, top_wr_i = 0, cw_ld_i = 0, sw_ld_i = 0;
  logic [3:0]  cc_i = 0;
  logic [2:0]  top_i = 0;
  logic [15:0] cw_ld_data_i = 0, sw_ld_data_i = 0;
  logic [15:0] cw_o, sw_o;
  logic        error_o;
  int total = 0, bad = 0;

  always #5 clk_i = ~clk_i;

  fpu_exc_ctrl dut (.*);

  function automatic logic [15:0] mk_sw(input logic [5:0] f, input logic sf,
      input logic [3:0] c, input logic [2:0] t, input logic [5:0] m);
    logic es;
    es = |(f & ~m);
    return {es, c[3], t, c[2], c[1], c[0], es, sf, f};
  endfunction

  task automatic chk(input logic ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk_i);
    init_i = 0; clr_exc_i = 0; rpt_valid_i = 0; rpt_stk_i = 0; rpt_c1_i = 0;
    rpt_exc_i = 0; cc_wr_i = 0; top_wr_i = 0; cw_ld_i = 0; sw_ld_i = 0;
  endtask

  task automatic ld_sw(input logic [15:0] d);
    sw_ld_i = 1; sw_ld_data_i = d; step();
  endtask

  task automatic ld_cw(input logic [15:0] d);
    cw_ld_i = 1; cw_ld_data_i = d; step();
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    bad++; total++;
    $display("FAIL watchdog expired act=0 exp=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [5:0] acc;
    repeat (3) @(negedge clk_i);
    chk(cw_o == 16'h037F, "R4 reset cw", cw_o, 16'h037F);
    chk(sw_o == 16'h0000, "R4 reset sw", sw_o, 16'h0000);
    rst_ni = 1;
    step();

    // R10 condition codes and TOP, exhaustive
    for (int c = 0; c < 16; c++)
      for (int t = 0; t < 8; t++) begin
        cc_wr_i = 1; cc_i = 4'(c); top_wr_i = 1; top_i = 3'(t); step();
        chk(sw_o == mk_sw(6'h0, 1'b0, 4'(c), 3'(t), 6'h3F), "R10 cc/top", sw_o,
            mk_sw(6'h0, 1'b0, 4'(c), 3'(t), 6'h3F));
      end
    // state: cc=F top=7

    // R5 sticky accumulation, masked so no error (R1)
    acc = 0;
    for (int i = 0; i < 6; i++) begin
      rpt_valid_i = 1; rpt_exc_i = 6'(1 << i); step();
      acc |= 6'(1 << i);
      chk(sw_o[5:0] == acc, "R5 sticky or", {10'h0, sw_o[5:0]}, {10'h0, acc});
      chk(error_o == 0, "R1 all masked", {15'h0, error_o}, 16'h0);
    end
    clr_exc_i = 1; step();
    chk(sw_o == mk_sw(6'h0, 0, 4'hF, 3'd7, 6'h3F), "R6 clear keeps cc/top", sw_o,
        mk_sw(6'h0, 0, 4'hF, 3'd7, 6'h3F));
    rpt_valid_i = 0; rpt_exc_i = 6'h3F; step();
    chk(sw_o[5:0] == 0, "R5 invalid report ignored", {10'h0, sw_o[5:0]}, 16'h0);

    // R7 stack fault, C1 wins over cc write
    cc_wr_i = 1; cc_i = 4'h0; rpt_valid_i = 1; rpt_stk_i = 1; rpt_c1_i = 1; step();
    chk(sw_o == mk_sw(6'h01, 1, 4'b0010, 3'd7, 6'h3F), "R7 overflow fault", sw_o,
        mk_sw(6'h01, 1, 4'b0010, 3'd7, 6'h3F));
    rpt_valid_i = 1; rpt_stk_i = 1; rpt_c1_i = 0; step();
    chk(sw_o[9] == 0 && sw_o[6] && sw_o[0], "R7 underflow fault", sw_o, 16'h0041);

    // R6 clear with same-cycle report
    clr_exc_i = 1; rpt_valid_i = 1; rpt_exc_i = 6'h10; step();
    chk(sw_o[6:0] == 7'h10, "R6 clear then or", {9'h0, sw_o[6:0]}, 16'h0010);

    // R1 R2 R3 R8 exhaustive flag/mask sweep
    for (int m = 0; m < 64; m++) begin
      ld_cw(16'h1340 | 16'(m));
      chk(cw_o == (16'h1340 | 16'(m)), "R8 cw load", cw_o, 16'h1340 | 16'(m));
      for (int f = 0; f < 64; f++) begin
        logic [15:0] e, d;
        logic [3:0] c;
        c = 4'(f) ^ 4'(m);
        e = mk_sw(6'(f), f[0] ^ f[5], c, 3'(f), 6'(m));
        d = e ^ 16'h8080;
        ld_sw(d);
        chk(sw_o == e && error_o == e[7], "R3 R1 R2 load and summary", sw_o, e);
      end
    end

    // R8 unmasking raises error on next cycle
    ld_cw(16'h037F);
    ld_sw(16'h0004);
    chk(error_o == 0, "R8 masked", {15'h0, error_o}, 16'h0);
    ld_cw(16'h037B);
    chk(error_o == 1 && sw_o[15] && sw_o[7], "R8 unmask error", sw_o, 16'h8084);

    // R9 bit 12 has no effect
    ld_cw(16'h137B);
    chk(error_o == 1, "R9 bit12 set", {15'h0, error_o}, 16'h1);
    ld_cw(16'h137F);
    chk(error_o == 0, "R9 bit12 masked", {15'h0, error_o}, 16'h0);

    // R11 load beats reports and clear
    sw_ld_i = 1; sw_ld_data_i = 16'h0002; rpt_valid_i = 1; rpt_exc_i = 6'h3C;
    clr_exc_i = 1; step();
    chk(sw_o == 16'h0002, "R11 load over report", sw_o, 16'h0002);
    // R11 init beats loads
    init_i = 1; sw_ld_i = 1; sw_ld_data_i = 16'h7F3F; cw_ld_i = 1; cw_ld_data_i = 16'h0000; step();
    chk(cw_o == 16'h037F, "R11 R4 init cw", cw_o, 16'h037F);
    chk(sw_o == 16'h0000 && !error_o, "R11 R4 init sw", sw_o, 16'h0000);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule